// File: doc/BRIEF.md
# Half-Cycle Multiplexed Bus Link

This block moves a wide synchronous data word between two pieces of logic over half as many wires. The word is split into a lower half and an upper half. The transmit side puts one half on the shared wires while the bus clock is high and the other half while it is low. The receive side holds the high-phase half in a transparent latch and takes the low-phase half straight off the wires. It then registers the rebuilt word on the next rising edge. The valid and ready handshake signals each have a wire of their own and are never multiplexed.

Logic on both sides launches and captures data only on rising clock edges, so the multiplexing is invisible to it. The half-select level arrives as a separate input, `mux_phase`. This is the bus clock as it is distributed to the switch and the latch. It follows `clk` with a small lag, so the rising-edge capture of the low-phase half always sees that half still on the wires. The default payload is 64 bits on 32 wires.

Top module: `hml_link`

## Requirements
- R1: While `rst` is high on a rising edge, and after it, until a word is offered, `out_valid` is 0 and `in_ready` is 1.
- R2: While `mux_phase` is 1, wire n of `link_wires` carries bit n of the word held by the transmit side. While `mux_phase` is 0, it carries bit n+DW/2 of that word.
- R3: The lower half of `out_data` equals the half that was on the wires during the high phase. That half is held in a latch that closes when `mux_phase` falls.
- R4: The upper half of `out_data` equals the half on the wires in the low phase. It is taken directly from the wires, with no storage, at the rising edge.
- R5: A word accepted at rising edge k (`in_valid` and `in_ready` both 1) appears on `out_data` with `out_valid` = 1 right after rising edge k+1, not earlier.
- R6: With `out_ready` held at 1, `in_ready` stays 1, and a new word can be accepted on every rising edge with no gap cycles.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` do not change. Every accepted word is delivered exactly once and in order.
- R8: `in_ready` falls to 0 only when both the transmit stage and the receive stage hold a word and `out_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all registers use its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mux_phase | input | 1 | Half-select level, a slightly lagging copy of `clk` |
| in_valid | input | 1 | Source offers a word |
| in_ready | output | 1 | Transmit stage can take a word |
| in_data | input | DW | Word from the source |
| link_wires | output | DW/2 | The shared multiplexed wires |
| out_valid | output | 1 | Rebuilt word available |
| out_ready | input | 1 | Sink takes the word |
| out_data | output | DW | Rebuilt word |

## Verification
Two things can happen on the same rising edge. The receive register can capture the latched high half together with the live low half of one word while the transmit register launches the next word onto the same wires. A back-to-back stream with `out_ready` held high, and a long random run with random source and sink stalls, provoke this on nearly every edge. Each delivered word is compared against an in-order model built from the accepted words, so any mix of halves from neighbouring words is detected. Separate tests probe the wires in each clock phase and the exact cycle at which a word first appears.

// File: rtl/hml_pkg.sv
package hml_pkg;
  // Level of the half-select: which payload half occupies the wires
  typedef enum logic {
    PH_LOW  = 1'b0,  // upper half on the wires
    PH_HIGH = 1'b1   // lower half on the wires
  } hml_phase_e;
endpackage

// File: rtl/hml_tx.sv
module hml_tx
  import hml_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mux_phase,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          link_ready,
  output logic          link_valid,
  output logic [DW-1:0] tx_word,
  output logic [DW/2-1:0] link_wires
);
  localparam int HW = DW / 2;

  logic       tx_valid;
  hml_phase_e ph;

  assign ph         = hml_phase_e'(mux_phase);
  assign in_ready   = !tx_valid || link_ready;
  assign link_valid = tx_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_word  <= '0;
    end else if (in_ready) begin
      tx_valid <= in_valid;
      if (in_valid) tx_word <= in_data;
    end
  end

  // one 2:1 switch per shared wire, steered by the clock level
  for (genvar n = 0; n < HW; n++) begin : g_wire
    assign link_wires[n] = (ph == PH_HIGH) ? tx_word[n] : tx_word[n+HW];
  end

  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !link_ready) |=> (tx_valid && $stable(tx_word)));
endmodule

// File: rtl/hml_rx_latch.sv
module hml_rx_latch #(
  parameter int HW = 32
) (
  input  logic          mux_phase,
  input  logic [HW-1:0] link_wires,
  output logic [HW-1:0] a_hold
);
  // transparent while the phase is high, closes on its falling level
  for (genvar n = 0; n < HW; n++) begin : g_bit
    always_latch begin
      if (mux_phase) a_hold[n] = link_wires[n];
    end
  end
endmodule

// File: rtl/hml_rx.sv
module hml_rx #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW/2-1:0] a_hold,
  input  logic [DW/2-1:0] link_wires,
  input  logic          link_valid,
  output logic          link_ready,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  assign link_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (link_ready) begin
      out_valid <= link_valid;
      if (link_valid) out_data <= {link_wires, a_hold};
    end
  end

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R5
  take_word_chk: assert property (@(posedge clk) disable iff (rst)
    (link_valid && link_ready) |=> out_valid);

  // R8
  empty_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> link_ready);
endmodule

// File: rtl/hml_link.sv
module hml_link #(
  parameter int DW = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mux_phase,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [DW-1:0]   in_data,
  output logic [DW/2-1:0] link_wires,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [DW-1:0]   out_data
);
  localparam int HW = DW / 2;

  logic          link_valid;
  logic          link_ready;
  logic [DW-1:0] tx_word;
  logic [HW-1:0] a_hold;

  hml_tx #(.DW(DW)) tx_i (
    .clk(clk), .rst(rst), .mux_phase(mux_phase),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .link_ready(link_ready), .link_valid(link_valid),
    .tx_word(tx_word), .link_wires(link_wires)
  );

  hml_rx_latch #(.HW(HW)) lat_i (
    .mux_phase(mux_phase), .link_wires(link_wires), .a_hold(a_hold)
  );

  hml_rx #(.DW(DW)) rx_i (
    .clk(clk), .rst(rst), .a_hold(a_hold), .link_wires(link_wires),
    .link_valid(link_valid), .link_ready(link_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // R3
  a_latch_chk: assert property (@(posedge clk) disable iff (rst)
    link_valid |-> (a_hold == tx_word[HW-1:0]));

  // R4
  b_wire_chk: assert property (@(posedge clk) disable iff (rst)
    link_valid |-> (link_wires == tx_word[DW-1:HW]));

  // R6
  flow_ready_chk: assert property (@(posedge clk) disable iff (rst)
    out_ready |-> in_ready);
endmodule

// File: tb/hml_link_tb_top.sv
`timescale 1ns/1ps
module hml_link_tb_top;
  localparam int DW = 64;
  localparam int HW = DW / 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mux_phase = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic [HW-1:0] link_wires;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [DW-1:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] expq[$];

  hml_link #(.DW(DW)) dut_i (
    .clk(clk), .rst(rst), .mux_phase(mux_phase),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .link_wires(link_wires), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  initial forever #10 clk = ~clk;   // 50 MHz
  always begin
    @(clk);
    #1 mux_phase = clk;             // distributed copy lags by 1 ns
  end

  task automatic check(input bit ok, input string req,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rnd_word();
    return {$urandom, $urandom};
  endfunction

  // one cycle: drive at the falling edge, account for the next rising edge
  task automatic step(input bit v, input logic [DW-1:0] d, input bit r);
    @(negedge clk);
    in_valid  = v;
    in_data   = d;
    out_ready = r;
    #1;
    if (in_valid && in_ready) expq.push_back(in_data);
    if (out_valid && out_ready) begin
      if (expq.size() == 0) begin
        check(1'b0, "R7 unexpected word", out_data, '0);
      end else begin
        logic [DW-1:0] e;
        e = expq.pop_front();
        check(out_data[HW-1:0] == e[HW-1:0], "R3 lower half", out_data, e);
        check(out_data[DW-1:HW] == e[DW-1:HW], "R4 upper half", out_data, e);
      end
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 6; i++) step(1'b0, '0, 1'b1);
    check(expq.size() == 0, "R7 all words delivered", DW'(expq.size()), '0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", DW'(out_valid), '0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", DW'(out_valid), '0);
    check(in_ready == 1'b1, "R1 in_ready after reset", DW'(in_ready), 1);
  endtask

  task automatic t_mapping();
    logic [DW-1:0] w;
    w = 64'hA5A5_0F0F_3C3C_9696;
    @(negedge clk);
    in_valid = 1'b1; in_data = w; out_ready = 1'b1;
    @(posedge clk);
    #5;
    check(link_wires == w[HW-1:0], "R2 high phase wires", DW'(link_wires), DW'(w[HW-1:0]));
    @(negedge clk);
    in_valid = 1'b0;
    #3;
    check(link_wires == w[DW-1:HW], "R2 low phase wires", DW'(link_wires), DW'(w[DW-1:HW]));
    repeat (4) @(negedge clk);
  endtask

  task automatic t_latency();
    logic [DW-1:0] w;
    w = 64'h1234_5678_9ABC_DEF0;
    @(negedge clk);
    in_valid = 1'b1; in_data = w; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check(out_valid == 1'b0, "R5 not after one edge", DW'(out_valid), '0);
    @(negedge clk);
    #1;
    check(out_valid == 1'b1, "R5 valid after two edges", DW'(out_valid), 1);
    check(out_data[HW-1:0] == w[HW-1:0], "R3 latched half", out_data, w);
    check(out_data[DW-1:HW] == w[DW-1:HW], "R4 through half", out_data, w);
    @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R5 single word only", DW'(out_valid), '0);
  endtask

  task automatic t_stream();
    for (int i = 0; i < 60; i++) begin
      step(1'b1, rnd_word(), 1'b1);
      check(in_ready == 1'b1, "R6 in_ready in stream", DW'(in_ready), 1);
      if (i >= 2) check(out_valid == 1'b1, "R6 no gap", DW'(out_valid), 1);
    end
    drain();
  endtask

  task automatic t_fill();
    logic [DW-1:0] w1;
    w1 = rnd_word();
    step(1'b1, w1, 1'b0);
    check(in_ready == 1'b1, "R8 ready with empty rx", DW'(in_ready), 1);
    step(1'b1, rnd_word(), 1'b0);
    check(in_ready == 1'b1, "R8 ready with one word", DW'(in_ready), 1);
    for (int i = 0; i < 4; i++) begin
      step(1'b1, rnd_word(), 1'b0);
      check(in_ready == 1'b0, "R8 full and stalled", DW'(in_ready), '0);
      check(out_valid == 1'b1 && out_data == w1, "R7 stalled word held", out_data, w1);
    end
    drain();
  endtask

  task automatic t_random();
    for (int i = 0; i < 3000; i++)
      step(($urandom % 4) != 0, rnd_word(), ($urandom % 3) != 0);
    drain();
  endtask

  initial begin
    #(200000 * 20);
    check(1'b0, "watchdog expired", '0, '0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_mapping();
    t_latency();
    t_stream();
    t_fill();
    t_random();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule